// File: doc/BRIEF.md
# Scan Transaction Sequencer with CPU Clock

This block is the host-side master of a bit-serial scan link to a target that runs on a clock the host supplies. It produces three timing outputs from one quarter-period tick: the serial clock, the serial data out, and a separate single-step clock for the target's processor. It also takes the serial data returned by the target.

A transaction starts with a request. The request carries a four-bit mask that picks which phases run. There are four phases: a processor clock pulse, one lone serial clock pulse that makes the target take a parallel load, a full scan of every bit of the transmit vector, and a closing processor clock pulse that is followed by one serial clock pulse. Enabled phases always run in that fixed order, and disabled phases are skipped without any delay.

During the scan, the transmit vector is shifted out most significant bit first. Each bit returned by the target is sampled as the serial clock rises and is assembled into the receive vector. Two free-running counters record every serial clock pulse and every processor clock pulse issued since reset.

Top module: `scan_txn_seq`

## Requirements
- R1: While reset is held and right after it, `sclk`, `cpu_clk`, `mosi`, `busy`, `done`, `rx_data`, `spi_pulses` and `cpu_pulses` are all zero.
- R2: Every high or low half of a generated pulse lasts exactly QPH asserted `qtick` cycles (QPH = 2 by default). A request starts a fresh count.
- R3: The enabled phases run in a fixed order: pre-CPU (`phase_en[0]`), pre-SPI (`phase_en[1]`), scan (`phase_en[2]`), post-CPU (`phase_en[3]`). A disabled phase takes no time. `sclk` and `cpu_clk` are never high together.
- R4: The pre-CPU phase drives `cpu_clk` high for one half and then low for one half.
- R5: The pre-SPI phase drives `sclk` high for one half. In the cycle `sclk` falls, the next phase's outputs appear.
- R6: The scan phase puts `tx_data[NBITS-1]` on `mosi` one half before the first rising `sclk`. It then presents the bits in descending index order, and each bit is held through its high half.
- R7: In the cycle `sclk` rises during the scan, `miso` is shifted into `rx_data[0]` while older bits move up, so the first bit sampled ends in `rx_data[NBITS-1]`. After each fall `mosi` shows the next lower bit, and after the last fall it shows 0.
- R8: `rx_data` is cleared in the cycle a request is accepted, including a request with no phases enabled.
- R9: The post-CPU phase gives one `cpu_clk` pulse (a high half and a low half) followed by one `sclk` high half.
- R10: `spi_pulses` increases by one in each cycle `sclk` falls, and `cpu_pulses` in each cycle `cpu_clk` falls. At all other times both hold.
- R11: `done` is high for exactly one cycle, the first cycle in which `busy` is low again. A request with an all-zero mask raises `done` in the very next cycle and never raises `busy`.
- R12: A `start` seen while `busy` is ignored. The phase mask and `tx_data` are captured only when a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qtick | input | 1 | Quarter-period timing tick, one cycle wide |
| start | input | 1 | Transaction request, taken only when idle |
| phase_en | input | 4 | Phase select: bit0 pre-CPU, bit1 pre-SPI, bit2 scan, bit3 post-CPU |
| tx_data | input | NBITS | Transmit vector, bit NBITS-1 sent first |
| miso | input | 1 | Serial data from the target |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the target |
| cpu_clk | output | 1 | Target processor clock |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rx_data | output | NBITS | Receive vector |
| spi_pulses | output | CNT_W | Serial clock pulses since reset |
| cpu_pulses | output | CNT_W | Processor clock pulses since reset |

## Verification
The hardest situations to reach are a request that arrives partway through a long transaction with a different mask and vector, and the hand-offs between phases when the tick is irregular. A gapped tick can land in the same cycle as a phase boundary, which is where an off-by-one in the half-period timer would show. The stimulus covers both. It runs transactions under an every-cycle tick, an every-third-cycle tick and a pseudo-random gapped tick. It pulses a second request forty cycles into a busy scan, and it changes the mask and vector right after every accepted request. A behavioural segment-list model checks every output each cycle, including the all-disabled request.

// File: rtl/scan_txn_pkg.sv
`timescale 1ns/1ps
package scan_txn_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PCPU_HI,
        ST_PCPU_LO,
        ST_PSPI_HI,
        ST_SC_LEAD,
        ST_SC_HI,
        ST_SC_LO,
        ST_PST_HI,
        ST_PST_LO,
        ST_PST_SCK
    } seq_st_e;

    localparam int NUM_PHASES = 4;

    // First state of the earliest enabled phase whose index is >= from_ph.
    function automatic seq_st_e phase_entry(input logic [NUM_PHASES-1:0] en, input int from_ph);
        seq_st_e r;
        logic    hit;
        r   = ST_IDLE;
        hit = 1'b0;
        for (int k = 0; k < NUM_PHASES; k++) begin
            if (!hit && (k >= from_ph) && en[k]) begin
                hit = 1'b1;
                case (k)
                    0:       r = ST_PCPU_HI;
                    1:       r = ST_PSPI_HI;
                    2:       r = ST_SC_LEAD;
                    default: r = ST_PST_HI;
                endcase
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/scan_qtimer.sv
`timescale 1ns/1ps
module scan_qtimer #(
    parameter int QPH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic qtick,
    output logic adv
);
    localparam int QW = (QPH > 1) ? $clog2(QPH) : 1;

    logic [QW-1:0] cnt_q, cnt_d;

    assign adv = qtick && !clear && (cnt_q == QW'(QPH - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (qtick) begin
            cnt_d = adv ? '0 : cnt_q + QW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/scan_pulse_cnt.sv
`timescale 1ns/1ps
module scan_pulse_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] count_q, count_d;

    always_comb begin
        count_d = count_q;
        if (inc) count_d = count_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;
endmodule

// File: rtl/scan_shift_path.sv
`timescale 1ns/1ps
module scan_shift_path #(
    parameter int NBITS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NBITS-1:0] tx_in,
    input  logic             shift,
    input  logic             sample,
    input  logic             miso,
    output logic             lead_bit,
    output logic             next_bit,
    output logic [NBITS-1:0] rx
);
    typedef struct packed {
        logic [NBITS-1:0] tx;
        logic [NBITS-1:0] rx;
    } path_t;

    path_t p_q, p_d;

    always_comb begin
        p_d = p_q;
        if (load) begin
            p_d.tx = tx_in;
            p_d.rx = '0;
        end else begin
            if (shift)  p_d.tx = {p_q.tx[NBITS-2:0], 1'b0};
            if (sample) p_d.rx = {p_q.rx[NBITS-2:0], miso};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign lead_bit = p_q.tx[NBITS-1];
    assign next_bit = p_q.tx[NBITS-2];
    assign rx       = p_q.rx;
endmodule

// File: rtl/scan_txn_seq.sv
`timescale 1ns/1ps
module scan_txn_seq
    import scan_txn_pkg::*;
#(
    parameter int NBYTES = 8,
    parameter int QPH    = 2,
    parameter int CNT_W  = 16,
    parameter int NBITS  = NBYTES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             qtick,
    input  logic             start,
    input  logic [3:0]       phase_en,
    input  logic [NBITS-1:0] tx_data,
    input  logic             miso,
    output logic             sclk,
    output logic             mosi,
    output logic             cpu_clk,
    output logic             busy,
    output logic             done,
    output logic [NBITS-1:0] rx_data,
    output logic [CNT_W-1:0] spi_pulses,
    output logic [CNT_W-1:0] cpu_pulses
);
    localparam int BW = $clog2(NBITS + 1);

    typedef struct packed {
        seq_st_e         st;
        logic [3:0]      en;
        logic [BW-1:0]   bits;
        logic            sclk;
        logic            cpu;
        logic            mosi;
        logic            done;
    } ctl_t;

    ctl_t    c_q, c_d;
    logic    adv;
    logic    load, shift, sample, spi_inc, cpu_inc;
    logic    lead_bit, next_bit;
    logic    go;
    seq_st_e tgt;

    scan_qtimer #(.QPH(QPH)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (c_q.st == ST_IDLE),
        .qtick (qtick),
        .adv   (adv)
    );

    scan_shift_path #(.NBITS(NBITS)) u_path (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .tx_in    (tx_data),
        .shift    (shift),
        .sample   (sample),
        .miso     (miso),
        .lead_bit (lead_bit),
        .next_bit (next_bit),
        .rx       (rx_data)
    );

    scan_pulse_cnt #(.CNT_W(CNT_W)) u_spi_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (spi_inc),
        .count (spi_pulses)
    );

    scan_pulse_cnt #(.CNT_W(CNT_W)) u_cpu_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (cpu_inc),
        .count (cpu_pulses)
    );

    always_comb begin
        c_d     = c_q;
        c_d.done = 1'b0;
        load    = 1'b0;
        shift   = 1'b0;
        sample  = 1'b0;
        spi_inc = 1'b0;
        cpu_inc = 1'b0;
        go      = 1'b0;
        tgt     = c_q.st;

        // Exit actions: decide the next state and count falling edges.
        if (c_q.st == ST_IDLE) begin
            if (start) begin
                load     = 1'b1;
                c_d.en   = phase_en;
                c_d.bits = BW'(NBITS);
                go       = 1'b1;
                tgt      = phase_entry(phase_en, 0);
            end
        end else if (adv) begin
            go = 1'b1;
            case (c_q.st)
                ST_PCPU_HI: begin
                    cpu_inc = 1'b1;
                    tgt     = ST_PCPU_LO;
                end
                ST_PCPU_LO: tgt = phase_entry(c_q.en, 1);
                ST_PSPI_HI: begin
                    spi_inc = 1'b1;
                    tgt     = phase_entry(c_q.en, 2);
                end
                ST_SC_LEAD: tgt = ST_SC_HI;
                ST_SC_HI: begin
                    spi_inc  = 1'b1;
                    shift    = 1'b1;
                    c_d.bits = c_q.bits - BW'(1);
                    tgt      = ST_SC_LO;
                end
                ST_SC_LO: tgt = (c_q.bits == '0) ? phase_entry(c_q.en, 3) : ST_SC_HI;
                ST_PST_HI: begin
                    cpu_inc = 1'b1;
                    tgt     = ST_PST_LO;
                end
                ST_PST_LO:  tgt = ST_PST_SCK;
                ST_PST_SCK: begin
                    spi_inc = 1'b1;
                    tgt     = ST_IDLE;
                end
                default: tgt = ST_IDLE;
            endcase
        end

        // Entry actions: output levels of the state being entered.
        if (go) begin
            c_d.st   = tgt;
            c_d.sclk = 1'b0;
            c_d.cpu  = 1'b0;
            case (tgt)
                ST_IDLE:               c_d.done = 1'b1;
                ST_PCPU_HI, ST_PST_HI: c_d.cpu  = 1'b1;
                ST_PSPI_HI, ST_PST_SCK: c_d.sclk = 1'b1;
                ST_SC_HI: begin
                    c_d.sclk = 1'b1;
                    sample   = 1'b1;
                end
                ST_SC_LEAD: c_d.mosi = load ? tx_data[NBITS-1] : lead_bit;
                ST_SC_LO:   c_d.mosi = next_bit;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st   <= ST_IDLE;
            c_q.en   <= '0;
            c_q.bits <= '0;
            c_q.sclk <= 1'b0;
            c_q.cpu  <= 1'b0;
            c_q.mosi <= 1'b0;
            c_q.done <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign sclk    = c_q.sclk;
    assign mosi    = c_q.mosi;
    assign cpu_clk = c_q.cpu;
    assign busy    = (c_q.st != ST_IDLE);
    assign done    = c_q.done;
endmodule

// File: rtl/scan_txn_seq_chk.sv
`timescale 1ns/1ps
module scan_txn_seq_chk #(
    parameter int NBITS = 64,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sclk,
    input logic             cpu_clk,
    input logic             busy,
    input logic             done,
    input logic [NBITS-1:0] rx_data,
    input logic [CNT_W-1:0] spi_pulses,
    input logic [CNT_W-1:0] cpu_pulses
);
    // R3: the two clocks are never high together
    a_r3_clocks_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk && cpu_clk));

    // R2: a high half spans at least two ticks, hence at least two cycles
    a_r2_sclk_high_min: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |=> sclk);

    // R2
    a_r2_cpu_high_min: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_clk) |=> cpu_clk);

    // R10: serial pulse count steps on each falling serial clock
    a_r10_spi_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> (spi_pulses == CNT_W'($past(spi_pulses) + CNT_W'(1))));

    // R10
    a_r10_spi_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(sclk) |-> $stable(spi_pulses));

    // R10
    a_r10_cpu_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_clk) |-> (cpu_pulses == CNT_W'($past(cpu_pulses) + CNT_W'(1))));

    // R10
    a_r10_cpu_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(cpu_clk) |-> $stable(cpu_pulses));

    // R11: done is a single-cycle pulse outside a transaction
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8: receive vector is empty when a transaction begins
    a_r8_rx_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (rx_data == '0));

    // R11: clocks rest low when idle
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk && !cpu_clk));
endmodule

bind scan_txn_seq scan_txn_seq_chk #(.NBITS(NBITS), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk       (sclk),
    .cpu_clk    (cpu_clk),
    .busy       (busy),
    .done       (done),
    .rx_data    (rx_data),
    .spi_pulses (spi_pulses),
    .cpu_pulses (cpu_pulses)
);

// File: tb/scan_txn_seq_tb.sv
`timescale 1ns/1ps
module scan_txn_seq_tb;
    localparam int NB  = 8;
    localparam int W   = NB * 8;
    localparam int CW  = 16;
    localparam int QPH = 2;
    localparam int MAXSEG = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          qtick = 1'b0;
    logic          start = 1'b0;
    logic [3:0]    phase_en = '0;
    logic [W-1:0]  tx_data = '0;
    logic          miso = 1'b0;
    logic          sclk, mosi, cpu_clk, busy, done;
    logic [W-1:0]  rx_data;
    logic [CW-1:0] spi_pulses, cpu_pulses;

    scan_txn_seq #(.NBYTES(NB), .QPH(QPH), .CNT_W(CW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .qtick      (qtick),
        .start      (start),
        .phase_en   (phase_en),
        .tx_data    (tx_data),
        .miso       (miso),
        .sclk       (sclk),
        .mosi       (mosi),
        .cpu_clk    (cpu_clk),
        .busy       (busy),
        .done       (done),
        .rx_data    (rx_data),
        .spi_pulses (spi_pulses),
        .cpu_pulses (cpu_pulses)
    );

    always #2.5 clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    // Stimulus sources for tick and serial input
    int          qmode = 0;
    int          cyc = 0;
    logic [15:0] lfsr = 16'hACE1;

    always @(negedge clk) begin
        cyc++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        miso = lfsr[5];
        case (qmode)
            0:       qtick = 1'b1;
            1:       qtick = (cyc % 3 == 0);
            default: qtick = lfsr[0] | lfsr[7];
        endcase
    end

    // Reference model: list of half-period segments per transaction
    int s_sclk [0:MAXSEG-1];
    int s_cpu  [0:MAXSEG-1];
    int s_mosi [0:MAXSEG-1];
    int s_samp [0:MAXSEG-1];
    int m_len = 0;
    bit m_active = 1'b0;
    int m_idx = 0;
    int m_q = 0;
    logic [W-1:0]  m_rx = '0;
    logic          e_sclk = 1'b0, e_cpu = 1'b0, e_mosi = 1'b0, e_done = 1'b0;
    logic [CW-1:0] e_spi = '0, e_cpn = '0;

    task automatic add_seg(input int sc, input int cp, input int mo, input int sa);
        s_sclk[m_len] = sc;
        s_cpu[m_len]  = cp;
        s_mosi[m_len] = mo;
        s_samp[m_len] = sa;
        m_len++;
    endtask

    task automatic build(input logic [3:0] en, input logic [W-1:0] tx);
        m_len = 0;
        if (en[0]) begin add_seg(0, 1, -1, 0); add_seg(0, 0, -1, 0); end
        if (en[1]) add_seg(1, 0, -1, 0);
        if (en[2]) begin
            add_seg(0, 0, int'(tx[W-1]), 0);
            for (int i = W - 1; i >= 0; i--) begin
                int mo;
                mo = 0;
                if (i > 0) mo = int'(tx[i-1]);
                add_seg(1, 0, int'(tx[i]), 1);
                add_seg(0, 0, mo, 0);
            end
        end
        if (en[3]) begin add_seg(0, 1, -1, 0); add_seg(0, 0, -1, 0); add_seg(1, 0, -1, 0); end
    endtask

    task automatic apply_seg(input int i);
        e_sclk = s_sclk[i][0];
        e_cpu  = s_cpu[i][0];
        if (s_mosi[i] >= 0) e_mosi = s_mosi[i][0];
        if (s_samp[i] != 0) m_rx = {m_rx[W-2:0], miso};
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 1'b0; m_rx = '0; e_sclk = 1'b0; e_cpu = 1'b0;
            e_mosi = 1'b0; e_done = 1'b0; e_spi = '0; e_cpn = '0;
        end else begin
            e_done = 1'b0;
            if (!m_active) begin
                if (start) begin
                    build(phase_en, tx_data);
                    m_rx  = '0;
                    m_idx = 0;
                    m_q   = 0;
                    if (m_len == 0) e_done = 1'b1;
                    else begin m_active = 1'b1; apply_seg(0); end
                end
            end else if (qtick) begin
                if (m_q == QPH - 1) begin
                    m_q = 0;
                    if (s_sclk[m_idx] != 0) e_spi = e_spi + 1'b1;
                    if (s_cpu[m_idx] != 0)  e_cpn = e_cpn + 1'b1;
                    m_idx++;
                    if (m_idx == m_len) begin
                        m_active = 1'b0; e_done = 1'b1; e_sclk = 1'b0; e_cpu = 1'b0;
                    end else apply_seg(m_idx);
                end else m_q++;
            end
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R2 R3 R5 R6 R9 sclk", 64'(sclk), 64'(e_sclk));
            check("R2 R3 R4 R9 cpu_clk", 64'(cpu_clk), 64'(e_cpu));
            check("R6 R7 mosi", 64'(mosi), 64'(e_mosi));
            check("R7 R8 rx_data", 64'(rx_data), 64'(m_rx));
            check("R10 spi_pulses", 64'(spi_pulses), 64'(e_spi));
            check("R10 cpu_pulses", 64'(cpu_pulses), 64'(e_cpn));
            check("R11 R12 busy", 64'(busy), 64'(m_active));
            check("R11 done", 64'(done), 64'(e_done));
        end
    end

    task automatic run(input logic [3:0] en, input logic [W-1:0] tx);
        @(negedge clk);
        phase_en = en;
        tx_data  = tx;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        phase_en = ~en;   // R12: later changes must not matter
        tx_data  = ~tx;
        while (m_active) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 sclk", 64'(sclk), 64'd0);
        check("R1 mosi", 64'(mosi), 64'd0);
        check("R1 cpu_clk", 64'(cpu_clk), 64'd0);
        check("R1 busy", 64'(busy), 64'd0);
        check("R1 done", 64'(done), 64'd0);
        check("R1 rx_data", 64'(rx_data), 64'd0);
        check("R1 spi_pulses", 64'(spi_pulses), 64'd0);
        check("R1 cpu_pulses", 64'(cpu_pulses), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 R4 R5 R6 R7 R9: all phases, dense and sparse ticks
        qmode = 0; run(4'b1111, 64'hA5C3_0F1E_9B27_6D48);
        qmode = 1; run(4'b1111, 64'h8000_0000_0000_0001);
        // R2 R6 R7: scan alone under gapped ticks
        qmode = 2; run(4'b0100, 64'h1234_5678_9ABC_DEF0);
        // R3: single phases and skipped phases
        qmode = 0; run(4'b0001, 64'hFFFF_FFFF_FFFF_FFFF);
        run(4'b0010, 64'h0);
        run(4'b1000, 64'h0);
        qmode = 2; run(4'b1101, 64'h0F0F_F0F0_3C3C_C3C3);
        run(4'b0110, 64'hFEDC_BA98_7654_3210);
        // R8 R11: empty mask finishes at once and clears rx
        qmode = 0; run(4'b0000, 64'h5555_5555_5555_5555);

        // R12: request during a busy scan is ignored
        qmode = 1;
        @(negedge clk);
        phase_en = 4'b1111; tx_data = 64'hC0DE_CAFE_0123_4567; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        phase_en = 4'b0001; tx_data = 64'h0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (m_active) @(negedge clk);
        repeat (3) @(negedge clk);

        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        summary();
    end
endmodule